// File: doc/BRIEF.md
# Dual-Port GPIO Interrupt Controller

This block watches a bank of GPIO input lines, grouped into two ports of sixteen pins, and turns activity on them into interrupt requests. Each line is configured with three bits that together select one of five triggers: any edge, rising edge, falling edge, high level or low level. There is no setting that turns detection off. Every line therefore keeps collecting events in a sticky flag at all times. A separate per-line enable decides only whether that flag reaches its port's interrupt output.

Software reaches the block through a word-wide register interface. It writes the three trigger vectors and the enable vector, and it reads the flags. It clears flags by writing ones to them. It can also read the synchronised pin state. A driver is expected to follow a fixed order: change the trigger, clear the flag, then set the enable. A flag raised while the configuration is changing stays set until software clears it.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is low (synchronous, active-low), the edge, both-edges, polarity, enable and flag registers all read 0, and both IRQ outputs are 0.
- R2: The register words are at byte offsets 0x00 (edge-detect vector), 0x04 (both-edges vector), 0x08 (polarity vector), 0x0C (enable vector), 0x10 (flags) and 0x14 (raw pin state). Offsets 0x00 to 0x0C read back the last value written. Bit i of every register belongs to line i, where i = port*16 + pin, so port A is bits 0-15 and port B is bits 16-31.
- R3: Offset 0x14 returns the pins after a two-flop synchroniser, so a pin change shows up there after two rising clock edges. Writes to offset 0x14 have no effect.
- R4: With edge=1 and both=1, a line flags on any edge. With edge=1, both=0 and polarity=1, it flags on a rising edge only. With edge=1, both=0 and polarity=0, it flags on a falling edge only. An edge is the synchronised value differing from its value one cycle earlier.
- R5: With edge=0, a line flags while its synchronised level is high (polarity=1) or low (polarity=0). The flag is set on every cycle the active level is present. A clear written in such a cycle loses to the set, so the flag still reads 1 afterwards.
- R6: A flag stays set until software writes 1 to its bit at offset 0x10. Writing 0 to a flag bit changes nothing.
- R7: Flags are set whatever the enable bits hold. After reset every line is in low-level mode, so with all pins low every flag reads 1 shortly after reset, while both IRQ outputs stay 0.
- R8: IRQ output bit 0 is 1 exactly when some port A line has both its flag and its enable set, and bit 1 does the same for port B. The outputs follow the flag and enable registers without an added cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_i | input | 32 | Asynchronous GPIO inputs, bit = port*16 + pin |
| wr_en | input | 1 | Register write strobe, takes effect at the rising edge |
| addr | input | 5 | Byte address of the register word (low two bits ignored) |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq_o | output | 2 | Interrupt request per port (bit 0 port A, bit 1 port B) |

## Verification
A wrong flag bit shows up on the flag word at the next read, and it reaches an IRQ output in the same cycle once the matching enable is set. A wrong trigger decode or a stale previous-sample register makes a flag appear or go missing three edges after the pin moves. Some faults only show in particular situations. A synchroniser stage that is missing or extra shows only as a one-cycle shift in the raw-state word. A broken clear priority shows only in level mode, where a cleared flag would read 0 for one cycle.

// File: rtl/gic_pkg.sv
// Package: shared types and register word indices for the GPIO interrupt controller.
// Assumes word-aligned byte addressing; indices are byte offset / 4.
package gic_pkg;
    localparam int IDX_EDGE = 0;
    localparam int IDX_BOTH = 1;
    localparam int IDX_POL  = 2;
    localparam int IDX_EN   = 3;
    localparam int IDX_FLAG = 4;
    localparam int IDX_RAW  = 5;

    // Per-line trigger selection bits
    typedef struct packed {
        logic edge_en;
        logic both_en;
        logic pol_hi;
    } trig_t;
endpackage

// File: rtl/gic_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency required).
module gic_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: shift the sampled value one stage down the chain
            always_ff @(posedge clk) begin
                if (!rst_n)      stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= d_i;
                else             stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gic_detect.sv
// Module: per-line trigger decode producing a one-cycle "hit" for each line.
// Assumes cur_i/prv_i are synchronised samples one cycle apart.
module gic_detect
    import gic_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prv_i,
    input  logic [W-1:0] edge_i,
    input  logic [W-1:0] both_i,
    input  logic [W-1:0] pol_i,
    output logic [W-1:0] hit_o
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_line
            trig_t cfg;
            logic  rise, fall, lvl;
            assign cfg  = '{edge_en: edge_i[i], both_en: both_i[i], pol_hi: pol_i[i]};
            assign rise = cur_i[i] & ~prv_i[i];
            assign fall = ~cur_i[i] & prv_i[i];
            assign lvl  = cfg.pol_hi ? cur_i[i] : ~cur_i[i];

            // Purpose: select the event condition named by the three config bits
            always_comb begin
                if (!cfg.edge_en)     hit_o[i] = lvl;
                else if (cfg.both_en) hit_o[i] = rise | fall;
                else if (cfg.pol_hi)  hit_o[i] = rise;
                else                  hit_o[i] = fall;
            end
        end
    endgenerate
endmodule

// File: rtl/gic_port_or.sv
// Module: folds masked flags into one interrupt request per port.
// Assumes lines are packed port-major: line = port*PINS + pin.
module gic_port_or #(
    parameter int PORTS = 2,
    parameter int PINS  = 16,
    localparam int W    = PORTS * PINS
) (
    input  logic [W-1:0]     flag_i,
    input  logic [W-1:0]     en_i,
    output logic [PORTS-1:0] irq_o
);
    logic [W-1:0] active;
    assign active = flag_i & en_i;

    generate
        for (genvar p = 0; p < PORTS; p++) begin : g_port
            // Purpose: any enabled pending line of this port raises its request
            assign irq_o[p] = |active[p*PINS +: PINS];
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Module: GPIO interrupt controller top. Holds the trigger, enable and flag
// registers, decodes the register interface and wires the sub-blocks.
// Assumes a single-cycle write strobe and a combinational read path.
module gpio_irq_ctrl
    import gic_pkg::*;
#(
    parameter int NUM_PORTS     = 2,
    parameter int PINS_PER_PORT = 16,
    parameter int SYNC_STAGES   = 2,
    parameter int ADDR_W        = 5,
    localparam int NL           = NUM_PORTS * PINS_PER_PORT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NL-1:0]        pins_i,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NL-1:0]        wr_data,
    output logic [NL-1:0]        rd_data,
    output logic [NUM_PORTS-1:0] irq_o
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] widx;
    logic [NL-1:0] edge_q, both_q, pol_q, en_q, flag_q;
    logic [NL-1:0] cur_s, prv_q, hit, clr_mask;

    assign widx = addr[ADDR_W-1:2];

    gic_sync #(.W(NL), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(cur_s)
    );

    // Purpose: keep the previous synchronised sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prv_q <= '0;
        else        prv_q <= cur_s;
    end

    gic_detect #(.W(NL)) u_detect (
        .cur_i(cur_s), .prv_i(prv_q), .edge_i(edge_q), .both_i(both_q),
        .pol_i(pol_q), .hit_o(hit)
    );

    // Purpose: configuration and enable registers written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
            both_q <= '0;
            pol_q  <= '0;
            en_q   <= '0;
        end else if (wr_en) begin
            if (widx == WORD_W'(IDX_EDGE)) edge_q <= wr_data;
            if (widx == WORD_W'(IDX_BOTH)) both_q <= wr_data;
            if (widx == WORD_W'(IDX_POL))  pol_q  <= wr_data;
            if (widx == WORD_W'(IDX_EN))   en_q   <= wr_data;
        end
    end

    // Purpose: write-one-to-clear mask for the flag word
    assign clr_mask = (wr_en && widx == WORD_W'(IDX_FLAG)) ? wr_data : '0;

    // Purpose: sticky flags; a detection in the same cycle beats a clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_mask) | hit;
    end

    // Purpose: combinational read multiplexer
    always_comb begin
        rd_data = '0;
        if      (widx == WORD_W'(IDX_EDGE)) rd_data = edge_q;
        else if (widx == WORD_W'(IDX_BOTH)) rd_data = both_q;
        else if (widx == WORD_W'(IDX_POL))  rd_data = pol_q;
        else if (widx == WORD_W'(IDX_EN))   rd_data = en_q;
        else if (widx == WORD_W'(IDX_FLAG)) rd_data = flag_q;
        else if (widx == WORD_W'(IDX_RAW))  rd_data = cur_s;
    end

    gic_port_or #(.PORTS(NUM_PORTS), .PINS(PINS_PER_PORT)) u_or (
        .flag_i(flag_q), .en_i(en_q), .irq_o(irq_o)
    );
endmodule

// File: rtl/gic_checker.sv
// Module: property checker for gpio_irq_ctrl, attached by bind.
// Assumes it sees the top's flag, enable, hit and clear-mask signals.
module gic_checker #(
    parameter int PORTS = 2,
    parameter int PINS  = 16,
    localparam int W    = PORTS * PINS
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     flag_q,
    input logic [W-1:0]     en_q,
    input logic [W-1:0]     edge_q,
    input logic [W-1:0]     hit,
    input logic [W-1:0]     clr_mask,
    input logic [PORTS-1:0] irq_o
);
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (flag_q == '0 && en_q == '0 && edge_q == '0)); // R1

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(flag_q) & ~flag_q) & ~$past(clr_mask)) == '0)); // R6

    AST_HIT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((flag_q & $past(hit)) == $past(hit))); // R5

    generate
        for (genvar p = 0; p < PORTS; p++) begin : g_irq
            AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
                (en_q[p*PINS +: PINS] == '0) |-> !irq_o[p]); // R8
            AST_IRQ_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_q[p*PINS +: PINS] == '0) |-> !irq_o[p]); // R7
        end
    endgenerate
endmodule

bind gpio_irq_ctrl gic_checker #(.PORTS(NUM_PORTS), .PINS(PINS_PER_PORT)) u_chk (
    .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .en_q(en_q), .edge_q(edge_q),
    .hit(hit), .clr_mask(clr_mask), .irq_o(irq_o)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pins_i = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [1:0]  irq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] v;

    always #5 clk = ~clk;

    gpio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pins_i(pins_i), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    // Vector: {edge, both, pol, init pins, final pins}
    localparam int NV = 6;
    localparam logic [66:0] VEC [NV] = '{
        {3'b110, 32'h0000FFFF, 32'h00FF00FF},  // any edge
        {3'b101, 32'h0F0F0F0F, 32'hFF00FF00},  // rising
        {3'b100, 32'h0F0F0F0F, 32'hFF00FF00},  // falling
        {3'b001, 32'h00000000, 32'h80000001},  // high level
        {3'b000, 32'hFFFFFFFF, 32'h7FFFFFFE},  // low level
        {3'b101, 32'hAAAAAAAA, 32'h55555555}   // rising, alternating
    };

    function automatic logic [31:0] model(input logic [2:0] c, input logic [31:0] a,
                                          input logic [31:0] b);
        if (!c[2]) return c[0] ? (a | b) : (~a | ~b);
        if (c[1])  return a ^ b;
        return c[0] ? (~a & b) : (a & ~b);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        wait_cyc(3);
        for (int a = 0; a < 5; a++) begin
            rd(5'(a * 4), v);
            chk("R1 reg during reset", v, 32'h0);
        end
        chk("R1 irq during reset", {30'h0, irq_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R7: default low-level mode collects flags with enables off
        wait_cyc(4);
        rd(5'h10, v); chk("R7 flags after reset", v, 32'hFFFFFFFF);
        chk("R7 irq masked", {30'h0, irq_o}, 32'h0);

        // R2: register readback
        wr(5'h00, 32'hA5A5_0F0F); rd(5'h00, v); chk("R2 edge readback", v, 32'hA5A5_0F0F);
        wr(5'h04, 32'h1234_5678); rd(5'h04, v); chk("R2 both readback", v, 32'h1234_5678);
        wr(5'h08, 32'hC3C3_9999); rd(5'h08, v); chk("R2 pol readback", v, 32'hC3C3_9999);

        // R3: raw pin state after synchroniser, read-only
        @(negedge clk); pins_i = 32'hDEAD_BEEF;
        wait_cyc(1); rd(5'h14, v); chk("R3 raw after one edge", v, 32'h0);
        wait_cyc(1); rd(5'h14, v); chk("R3 raw after two edges", v, 32'hDEAD_BEEF);
        wr(5'h14, 32'h0); rd(5'h14, v); chk("R3 raw ignores write", v, 32'hDEAD_BEEF);

        // R4/R5: table of trigger modes
        for (int i = 0; i < NV; i++) begin
            logic [2:0]  c;
            logic [31:0] a, b;
            {c, a, b} = VEC[i];
            wr(5'h00, {32{c[2]}});
            wr(5'h04, {32{c[1]}});
            wr(5'h08, {32{c[0]}});
            pins_i = a;
            wait_cyc(5);
            wr(5'h10, 32'hFFFFFFFF);
            pins_i = b;
            wait_cyc(5);
            rd(5'h10, v);
            chk(c[2] ? "R4 edge vector" : "R5 level vector", v, model(c, a, b));
        end

        // R6: sticky flags and write-1-to-clear
        wr(5'h00, 32'hFFFFFFFF); wr(5'h04, 32'h0); wr(5'h08, 32'hFFFFFFFF);
        pins_i = 32'h0; wait_cyc(5);
        wr(5'h10, 32'hFFFFFFFF);
        rd(5'h10, v); chk("R6 cleared", v, 32'h0);
        pins_i = 32'h000F_0003; wait_cyc(5);
        rd(5'h10, v); chk("R6 rising flags", v, 32'h000F_0003);
        wr(5'h10, 32'h0); rd(5'h10, v); chk("R6 write 0 no effect", v, 32'h000F_0003);
        wr(5'h10, 32'h1); rd(5'h10, v); chk("R6 partial clear", v, 32'h000F_0002);
        wait_cyc(3); rd(5'h10, v); chk("R6 flag stays", v, 32'h000F_0002);

        // R8: per-port IRQ aggregation
        chk("R8 no enable", {30'h0, irq_o}, 32'h0);
        wr(5'h0C, 32'h0000_0002); chk("R8 port A", {30'h0, irq_o}, 32'h1);
        wr(5'h0C, 32'h0001_0000); chk("R8 port B", {30'h0, irq_o}, 32'h2);
        wr(5'h0C, 32'h0001_0002); chk("R8 both ports", {30'h0, irq_o}, 32'h3);
        wr(5'h0C, 32'hFFF0_0001); chk("R8 enabled lines idle", {30'h0, irq_o}, 32'h0);
        wr(5'h10, 32'hFFFFFFFF); wr(5'h0C, 32'hFFFFFFFF);
        chk("R8 all cleared", {30'h0, irq_o}, 32'h0);
        wr(5'h0C, 32'h0);

        // R5: clear loses to a persisting active level
        wr(5'h00, 32'h0); wr(5'h08, 32'h0);
        pins_i = 32'h0; wait_cyc(5);
        wr(5'h10, 32'hFFFFFFFF);
        rd(5'h10, v); chk("R5 low level overrides clear", v, 32'hFFFFFFFF);
        wr(5'h08, 32'hFFFFFFFF); wait_cyc(2);
        wr(5'h10, 32'hFFFFFFFF);
        rd(5'h10, v); chk("R5 inactive level clears", v, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule